// File: doc/BRIEF.md
# Banked Interrupt Distributor Register File

This block is the register storage of an interrupt distributor that serves up to eight processors. It keeps three bit arrays (enable, pending, active), one bit per interrupt packed 32 to a word, together with an 8-bit priority and an 8-bit processor-target field for each interrupt. Every access carries the identity of the requesting processor. Interrupts 0 to 31 are private to each processor, so the first word of each bit array and the priority bytes of those interrupts exist once per processor. Interrupts from 32 upward are stored once and shared by all processors.

Software changes the bit arrays through two views of each group. A write to the set view turns on the bits given as ones in the data. A write to the clear view turns off those bits. A read from either view returns the stored word. Bits 0 to 15 of the private pending word belong to software-generated interrupts, and register writes never change them. The priority and target arrays accept 1-, 2- or 4-byte accesses. The complete enable, pending, active and priority state of every processor is driven out in parallel to a downstream prioritiser, and every accepted pending write sends that prioritiser a strobe naming the word it touched.

The address map is a 12-bit byte offset. Set-enable is at 0x000 and clear-enable at 0x080. Set-pending is at 0x100 and clear-pending at 0x180. Set-active is at 0x200 and clear-active at 0x280. Priorities start at 0x400 plus the interrupt number, and targets start at 0x800 plus the interrupt number. Within a bit group the word index is offset[6:2]. The access width is given by `req_size`, which holds a byte count. Each request gets its response one cycle later.

Top module: `irq_dist_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, every enable, pending, active, priority and shared target value is cleared to zero, and `rsp_valid` and `upd_valid` are driven low.
- R2: A request in cycle t produces `rsp_valid`=1 in cycle t+1 and in no other cycle. For a successful read, `rsp_rdata` holds the addressed data as it was in cycle t. For a write, `rsp_rdata` is zero.
- R3: In the enable and active groups, a write to the set view (offset bit 7 = 0) ORs the data into the selected word. A write to the clear view (offset bit 7 = 1) clears every bit that is one in the data. A read from either view returns the same stored word.
- R4: Word index 0 of each bit group addresses the requester's private word for interrupts 0–31. Word index k>0 addresses the shared word for interrupts 32k to 32k+31, and every processor sees that word.
- R5: A set-pending or clear-pending write to word 0 leaves bits 15:0 unchanged and applies the data to bits 31:16. Writes to other pending words apply to all 32 bits.
- R6: A priority access of 1, 2 or 4 bytes at 0x400+n covers interrupts n to n+size−1. Interrupt n is in data bits 7:0, n+1 in 15:8, and so on. Bytes for interrupts below 32 are private to the requester. Bytes for higher interrupts are shared.
- R7: A target read at 0x800+n returns, for each interrupt below 32 that it covers, the byte (1 << cpu) of the requester. Target writes to those interrupts have no effect. Targets of interrupts 32 and above are shared bytes that can be read and written, and they use the lane order of R6.
- R8: A request is refused with `rsp_err`=1, `rsp_rdata`=0 and no state change in any of these cases: the size is not 1, 2 or 4; a bit-group access is not a 4-byte access on a 4-byte boundary; the word index is at or beyond NUM_IRQ/32; the offset lies in 0x300–0x3FF; a byte access is not aligned to its size or runs past NUM_IRQ; or the cpu identity is NUM_CPU or larger.
- R9: An accepted write to either pending view raises `upd_valid` for exactly the next cycle, with `upd_word` equal to the word index written. No other request raises `upd_valid`.
- R10: For processor c and interrupt i, `en_o`, `pend_o` and `act_o` bit c*NUM_IRQ+i and `prio_o` byte c*NUM_IRQ+i show the value that processor c would read for interrupt i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | Requesting processor |
| req_addr | input | 12 | Byte offset into the register map |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_err | output | 1 | Request refused |
| rsp_rdata | output | 32 | Read data |
| upd_valid | output | 1 | Pending state was written |
| upd_word | output | 5 | Word index of that pending write |
| en_o | output | NUM_CPU*NUM_IRQ | Enable bits for each processor |
| pend_o | output | NUM_CPU*NUM_IRQ | Pending bits for each processor |
| act_o | output | NUM_CPU*NUM_IRQ | Active bits for each processor |
| prio_o | output | NUM_CPU*NUM_IRQ*8 | Priority bytes for each processor |

## Verification
The assertions assume that the register contents change only through accepted writes on the request port. Because of that, they treat the software-interrupt pending bits as constant and expect the state to stay still in every cycle that follows a refused or absent request. They also assume that `rst_n` is held low for at least one edge before the first request, so the first past sample is a reset value. The stimulus keeps to these conditions: it holds reset for several cycles, drives one request followed by an idle cycle, and deliberately sends refused requests (bad sizes, misalignment, unmapped or out-of-range offsets) so that the properties about unchanged state are exercised.

// File: rtl/irq_dist_pkg.sv
// Shared definitions for the interrupt distributor register file.
// Assumes a 12-bit byte-offset map with the group layout given in the brief.
package irq_dist_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int WIDX_W = 5;   // up to 32 words per bit group
    localparam int BANK_IRQS = 32; // interrupts private to each processor
    localparam int SGI_BITS = 16;  // pending bits that writes must not touch

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_EN,
        GRP_PEND,
        GRP_ACT,
        GRP_PRIO,
        GRP_TGT
    } dist_grp_e;
endpackage

// File: rtl/irq_dist_decode.sv
// Address decoder: classifies a request into a register group and checks it.
// Assumes the top gates its outputs with req_valid; purely combinational.
module irq_dist_decode
    import irq_dist_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int NUM_IRQ = 64,
    parameter int CPU_W   = 3,
    parameter int IRQ_W   = 6
) (
    input  logic [CPU_W-1:0]  cpu,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output dist_grp_e         grp,
    output logic              clr,
    output logic [WIDX_W-1:0] word_idx,
    output logic [IRQ_W-1:0]  byte_id,
    output logic              err
);
    localparam int NUM_WORDS = NUM_IRQ / 32;

    logic        size_ok;
    logic [10:0] off_b;

    // Legal byte-group widths.
    assign size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);

    // Group selection and legality checks.
    always_comb begin
        grp      = GRP_NONE;
        clr      = addr[7];
        word_idx = addr[6:2];
        off_b    = '0;
        err      = 1'b1;
        case (addr[11:10])
            2'b00: begin
                case (addr[9:8])
                    2'b00:   grp = GRP_EN;
                    2'b01:   grp = GRP_PEND;
                    2'b10:   grp = GRP_ACT;
                    default: grp = GRP_NONE;
                endcase
                if (grp != GRP_NONE) begin
                    err = (size != 3'd4) || (addr[1:0] != 2'b00) ||
                          (int'(word_idx) >= NUM_WORDS);
                end
            end
            2'b01: begin
                grp   = GRP_PRIO;
                off_b = {1'b0, addr[9:0]};
            end
            default: begin
                grp   = GRP_TGT;
                off_b = addr[10:0];
            end
        endcase
        if (grp == GRP_PRIO || grp == GRP_TGT) begin
            err = !size_ok ||
                  ((off_b & {8'b0, size - 3'd1}) != 11'd0) ||
                  (int'(off_b) + int'(size) > NUM_IRQ);
        end
        if (int'(cpu) >= NUM_CPU) begin
            err = 1'b1;
        end
    end

    assign byte_id = off_b[IRQ_W-1:0];
endmodule

// File: rtl/irq_dist_bitbank.sv
// One bit array (enable, pending or active) with a private word 0 for each
// processor and shared higher words. Set/clear write semantics. When SGI_LOCK
// is set, writes to word 0 cannot change bits below SGI_BITS.
// Assumes the decoder has already checked the word index.
module irq_dist_bitbank
    import irq_dist_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int NUM_IRQ = 64,
    parameter int CPU_W   = 3,
    parameter bit SGI_LOCK = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       clr,
    input  logic [CPU_W-1:0]           cpu,
    input  logic [WIDX_W-1:0]          idx,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_CPU*NUM_IRQ-1:0] view
);
    localparam int NUM_WORDS = NUM_IRQ / 32;
    localparam int SH_W  = (NUM_WORDS > 1) ? NUM_WORDS - 1 : 1;
    localparam int SH_IW = (SH_W > 1) ? $clog2(SH_W) : 1;
    localparam logic [DATA_W-1:0] LOCK_MASK =
        SGI_LOCK ? ~((DATA_W'(1) << SGI_BITS) - DATA_W'(1)) : '1;

    logic [DATA_W-1:0] bank_q [NUM_CPU];
    logic [DATA_W-1:0] shr_q  [SH_W];
    logic [DATA_W-1:0] eff_data;
    logic [SH_IW-1:0]  sh_sel;

    // Data bits actually allowed to change for this write.
    assign eff_data = (idx == '0) ? (wdata & LOCK_MASK) : wdata;
    assign sh_sel   = SH_IW'(idx - WIDX_W'(1));

    // Storage update: OR for the set view, AND-NOT for the clear view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CPU; c++) bank_q[c] <= '0;
            for (int w = 0; w < SH_W; w++)    shr_q[w]  <= '0;
        end else if (wr_en) begin
            if (idx == '0) begin
                bank_q[cpu] <= clr ? (bank_q[cpu] & ~eff_data)
                                   : (bank_q[cpu] | eff_data);
            end else begin
                shr_q[sh_sel] <= clr ? (shr_q[sh_sel] & ~eff_data)
                                     : (shr_q[sh_sel] | eff_data);
            end
        end
    end

    // Read port: private word 0 or a shared word.
    assign rdata = (idx == '0) ? bank_q[cpu] : shr_q[sh_sel];

    // Parallel view for every processor.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign view[c*NUM_IRQ +: 32] = bank_q[c];
        for (genvar w = 1; w < NUM_WORDS; w++) begin : g_word
            assign view[c*NUM_IRQ + w*32 +: 32] = shr_q[w-1];
        end
    end
endmodule

// File: rtl/irq_dist_priobank.sv
// Priority bytes: private for interrupts below 32, shared above.
// Access of 1, 2 or 4 consecutive bytes; lowest interrupt in bits 7:0.
// Assumes the decoder has checked alignment and range; NUM_IRQ >= 64.
module irq_dist_priobank
    import irq_dist_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int NUM_IRQ = 64,
    parameter int CPU_W   = 3,
    parameter int IRQ_W   = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [CPU_W-1:0]             cpu,
    input  logic [IRQ_W-1:0]             base,
    input  logic [2:0]                   size,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic [NUM_CPU*NUM_IRQ*8-1:0] view
);
    localparam int SHN   = NUM_IRQ - BANK_IRQS;
    localparam int SH_IW = $clog2(SHN);

    logic [7:0]       bank_q [NUM_CPU][BANK_IRQS];
    logic [7:0]       shr_q  [SHN];
    logic [IRQ_W-1:0] lane_id [4];
    logic [SH_IW-1:0] lane_sh [4];
    logic             lane_on [4];

    // Interrupt number covered by each data lane.
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            lane_id[k] = base + IRQ_W'(k);
            lane_sh[k] = SH_IW'(lane_id[k] - IRQ_W'(BANK_IRQS));
            lane_on[k] = (k < int'(size));
        end
    end

    // Byte writes, one per active lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CPU; c++)
                for (int i = 0; i < BANK_IRQS; i++) bank_q[c][i] <= '0;
            for (int i = 0; i < SHN; i++) shr_q[i] <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < 4; k++) begin
                if (lane_on[k]) begin
                    if (int'(lane_id[k]) < BANK_IRQS)
                        bank_q[cpu][lane_id[k][4:0]] <= wdata[8*k +: 8];
                    else
                        shr_q[lane_sh[k]] <= wdata[8*k +: 8];
                end
            end
        end
    end

    // Read lanes; unused lanes return zero.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < 4; k++) begin
            if (lane_on[k]) begin
                if (int'(lane_id[k]) < BANK_IRQS)
                    rdata[8*k +: 8] = bank_q[cpu][lane_id[k][4:0]];
                else
                    rdata[8*k +: 8] = shr_q[lane_sh[k]];
            end
        end
    end

    // Parallel view for every processor.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
            if (i < BANK_IRQS) begin : g_bank
                assign view[(c*NUM_IRQ+i)*8 +: 8] = bank_q[c][i];
            end else begin : g_shr
                assign view[(c*NUM_IRQ+i)*8 +: 8] = shr_q[i-BANK_IRQS];
            end
        end
    end
endmodule

// File: rtl/irq_dist_tgtbank.sv
// Target bytes. Below interrupt 32 a read returns the requester's one-hot
// mask and writes are dropped; higher interrupts hold shared bytes.
// Assumes NUM_CPU <= 8 and a decoder-checked access.
module irq_dist_tgtbank
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int CPU_W   = 3,
    parameter int IRQ_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_W-1:0]  cpu,
    input  logic [IRQ_W-1:0]  base,
    input  logic [2:0]        size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int SHN   = NUM_IRQ - BANK_IRQS;
    localparam int SH_IW = $clog2(SHN);

    logic [7:0]       shr_q [SHN];
    logic [7:0]       own_mask;
    logic [IRQ_W-1:0] lane_id [4];
    logic [SH_IW-1:0] lane_sh [4];
    logic             lane_on [4];

    assign own_mask = 8'd1 << cpu;

    // Interrupt number covered by each data lane.
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            lane_id[k] = base + IRQ_W'(k);
            lane_sh[k] = SH_IW'(lane_id[k] - IRQ_W'(BANK_IRQS));
            lane_on[k] = (k < int'(size));
        end
    end

    // Shared byte writes; private lanes are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SHN; i++) shr_q[i] <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < 4; k++) begin
                if (lane_on[k] && int'(lane_id[k]) >= BANK_IRQS)
                    shr_q[lane_sh[k]] <= wdata[8*k +: 8];
            end
        end
    end

    // Read lanes: fixed mask below 32, stored byte above.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < 4; k++) begin
            if (lane_on[k]) begin
                if (int'(lane_id[k]) < BANK_IRQS)
                    rdata[8*k +: 8] = own_mask;
                else
                    rdata[8*k +: 8] = shr_q[lane_sh[k]];
            end
        end
    end
endmodule

// File: rtl/irq_dist_regs.sv
// Top of the banked interrupt distributor register file. Decodes each
// request, steers it to the bit, priority or target banks, registers a
// one-cycle response and a pending-update strobe.
// Assumes NUM_IRQ is a multiple of 32 between 64 and 1024, NUM_CPU <= 8.
module irq_dist_regs
    import irq_dist_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int NUM_IRQ = 64,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IRQ_W  = $clog2(NUM_IRQ)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [CPU_W-1:0]             req_cpu,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [2:0]                   req_size,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         rsp_valid,
    output logic                         rsp_err,
    output logic [DATA_W-1:0]            rsp_rdata,
    output logic                         upd_valid,
    output logic [WIDX_W-1:0]            upd_word,
    output logic [NUM_CPU*NUM_IRQ-1:0]   en_o,
    output logic [NUM_CPU*NUM_IRQ-1:0]   pend_o,
    output logic [NUM_CPU*NUM_IRQ-1:0]   act_o,
    output logic [NUM_CPU*NUM_IRQ*8-1:0] prio_o
);
    dist_grp_e         grp;
    logic              clr;
    logic [WIDX_W-1:0] word_idx;
    logic [IRQ_W-1:0]  byte_id;
    logic              dec_err;
    logic              hit, wr_go;
    logic [DATA_W-1:0] en_rd, pend_rd, act_rd, prio_rd, tgt_rd, rd_mux;

    irq_dist_decode #(
        .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W), .IRQ_W(IRQ_W)
    ) u_decode (
        .cpu(req_cpu), .addr(req_addr), .size(req_size),
        .grp(grp), .clr(clr), .word_idx(word_idx),
        .byte_id(byte_id), .err(dec_err)
    );

    assign hit   = req_valid && !dec_err;
    assign wr_go = hit && req_write;

    irq_dist_bitbank #(
        .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W), .SGI_LOCK(1'b0)
    ) u_en (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go && grp == GRP_EN),
        .clr(clr), .cpu(req_cpu), .idx(word_idx), .wdata(req_wdata),
        .rdata(en_rd), .view(en_o)
    );

    irq_dist_bitbank #(
        .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W), .SGI_LOCK(1'b1)
    ) u_pend (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go && grp == GRP_PEND),
        .clr(clr), .cpu(req_cpu), .idx(word_idx), .wdata(req_wdata),
        .rdata(pend_rd), .view(pend_o)
    );

    irq_dist_bitbank #(
        .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W), .SGI_LOCK(1'b0)
    ) u_act (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go && grp == GRP_ACT),
        .clr(clr), .cpu(req_cpu), .idx(word_idx), .wdata(req_wdata),
        .rdata(act_rd), .view(act_o)
    );

    irq_dist_priobank #(
        .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W), .IRQ_W(IRQ_W)
    ) u_prio (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go && grp == GRP_PRIO),
        .cpu(req_cpu), .base(byte_id), .size(req_size), .wdata(req_wdata),
        .rdata(prio_rd), .view(prio_o)
    );

    irq_dist_tgtbank #(
        .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W), .IRQ_W(IRQ_W)
    ) u_tgt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_go && grp == GRP_TGT),
        .cpu(req_cpu), .base(byte_id), .size(req_size), .wdata(req_wdata),
        .rdata(tgt_rd)
    );

    // Read data selection by group.
    always_comb begin
        case (grp)
            GRP_EN:   rd_mux = en_rd;
            GRP_PEND: rd_mux = pend_rd;
            GRP_ACT:  rd_mux = act_rd;
            GRP_PRIO: rd_mux = prio_rd;
            GRP_TGT:  rd_mux = tgt_rd;
            default:  rd_mux = '0;
        endcase
    end

    // Registered response and pending-update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            upd_valid <= 1'b0;
            upd_word  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && dec_err;
            rsp_rdata <= (hit && !req_write) ? rd_mux : '0;
            upd_valid <= wr_go && (grp == GRP_PEND);
            upd_word  <= (wr_go && grp == GRP_PEND) ? word_idx : '0;
        end
    end
endmodule

// File: rtl/irq_dist_regs_chk.sv
// Property checker for irq_dist_regs, attached by bind below.
// Assumes state is changed only through accepted requests.
module irq_dist_regs_chk
    import irq_dist_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int NUM_IRQ = 64
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_write,
    input logic                         rsp_valid,
    input logic                         rsp_err,
    input logic [DATA_W-1:0]            rsp_rdata,
    input logic                         upd_valid,
    input logic [WIDX_W-1:0]            upd_word,
    input logic [NUM_CPU*NUM_IRQ-1:0]   en_o,
    input logic [NUM_CPU*NUM_IRQ-1:0]   pend_o,
    input logic [NUM_CPU*NUM_IRQ-1:0]   act_o,
    input logic [NUM_CPU*NUM_IRQ*8-1:0] prio_o
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0)); // R8
    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($stable(en_o) && $stable(pend_o) && $stable(act_o) && $stable(prio_o))); // R8
    AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!req_valid) |-> ($stable(en_o) && $stable(pend_o) && $stable(act_o))); // R3
    AST_UPD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(req_valid && req_write)); // R9
    AST_UPD_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (int'(upd_word) < NUM_IRQ / 32)); // R9

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_sgi
        AST_SGI_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(pend_o[c*NUM_IRQ +: SGI_BITS])); // R5
    end
endmodule

bind irq_dist_regs irq_dist_regs_chk #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .upd_valid(upd_valid), .upd_word(upd_word), .en_o(en_o), .pend_o(pend_o),
    .act_o(act_o), .prio_o(prio_o)
);

// File: tb/irq_dist_regs_bench.sv
// Bench for irq_dist_regs: behavioural reference model compared after every
// request, plus directed checks with literal expectations.
module irq_dist_regs_bench;
    localparam int NC = 8;
    localparam int NI = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [2:0] req_cpu = '0;
    logic [11:0] req_addr = '0;
    logic [2:0] req_size = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid, rsp_err, upd_valid;
    logic [31:0] rsp_rdata;
    logic [4:0] upd_word;
    logic [NC*NI-1:0] en_o, pend_o, act_o;
    logic [NC*NI*8-1:0] prio_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Model state: every processor's view, shared entries kept equal.
    bit       m_bits [3][NC][NI];
    bit [7:0] m_prio [NC][NI];
    bit [7:0] m_tgt  [NI];

    always #5 clk = ~clk;

    irq_dist_regs #(.NUM_CPU(NC), .NUM_IRQ(NI)) u_irq_dist_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cpu(req_cpu), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .upd_valid(upd_valid), .upd_word(upd_word),
        .en_o(en_o), .pend_o(pend_o), .act_o(act_o), .prio_o(prio_o)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_views(input string tag);
        logic [NC*NI-1:0] e [3];
        logic [NC*NI*8-1:0] p;
        int bad = 0;
        for (int c = 0; c < NC; c++)
            for (int i = 0; i < NI; i++) begin
                for (int g = 0; g < 3; g++) e[g][c*NI+i] = m_bits[g][c][i];
                p[(c*NI+i)*8 +: 8] = m_prio[c][i];
            end
        checks++;
        if (en_o !== e[0]) bad++;
        if (pend_o !== e[1]) bad++;
        if (act_o !== e[2]) bad++;
        if (prio_o !== p) bad++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s R10: %0d view vectors differ (pend got %h expected %h)",
                     tag, bad, pend_o[63:0], e[1][63:0]);
        end
    endtask

    // Reference behaviour of one request, from the requirements.
    task automatic model(input bit wr, input int cpu, input int addr, input int size,
                         input logic [31:0] wd, output bit e, output logic [31:0] rd,
                         output bit up, output int upw);
        bit size_ok = (size == 1 || size == 2 || size == 4);
        e = 1; rd = '0; up = 0; upw = 0;
        if (addr < 'h300) begin
            int g = addr >> 8;
            bit clr = addr[7];
            int w = (addr >> 2) & 31;
            e = (size != 4) || (addr % 4 != 0) || (w >= NI / 32) || (cpu >= NC);
            if (e) return;
            for (int b = 0; b < 32; b++) begin
                int i = w * 32 + b;
                if (!wr) rd[b] = m_bits[g][cpu][i];
                else if (wd[b] && !(g == 1 && w == 0 && b < 16)) begin
                    if (w == 0) m_bits[g][cpu][i] = !clr;
                    else for (int c = 0; c < NC; c++) m_bits[g][c][i] = !clr;
                end
            end
            if (wr && g == 1) begin up = 1; upw = w; end
        end else if (addr >= 'h400) begin
            bit is_tgt = (addr >= 'h800);
            int off = is_tgt ? addr - 'h800 : addr - 'h400;
            e = !size_ok || (off % size != 0) || (off + size > NI) || (cpu >= NC);
            if (e) return;
            for (int k = 0; k < size; k++) begin
                int id = off + k;
                if (!wr) begin
                    if (is_tgt) rd[8*k +: 8] = (id < 32) ? (8'd1 << cpu) : m_tgt[id];
                    else rd[8*k +: 8] = m_prio[cpu][id];
                end else if (is_tgt) begin
                    if (id >= 32) m_tgt[id] = wd[8*k +: 8];
                end else if (id < 32) m_prio[cpu][id] = wd[8*k +: 8];
                else for (int c = 0; c < NC; c++) m_prio[c][id] = wd[8*k +: 8];
            end
        end
    endtask

    // One request, compared with the model in the cycle after it.
    task automatic req(input string tag, input bit wr, input int cpu, input int addr,
                       input int size, input logic [31:0] wd, output logic [31:0] got);
        bit e, up; logic [31:0] rd; int upw;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_cpu = 3'(cpu); req_addr = 12'(addr);
        req_size = 3'(size); req_wdata = wd;
        model(wr, cpu, addr, size, wd, e, rd, up, upw);
        @(negedge clk);
        req_valid = 0;
        got = rsp_rdata;
        chk({tag, " R2 rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " R8 rsp_err"}, 64'(rsp_err), 64'(e));
        chk({tag, " R2 rdata"}, 64'(rsp_rdata), 64'(rd));
        chk({tag, " R9 upd_valid"}, 64'(upd_valid), 64'(up));
        if (up) chk({tag, " R9 upd_word"}, 64'(upd_word), 64'(upw));
        chk_views(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 rsp_valid", 64'(rsp_valid), 0);
        chk("R1 upd_valid", 64'(upd_valid), 0);
        chk("R1 en/pend/act", 64'(|{en_o, pend_o, act_o}), 0);
        chk("R1 prio", 64'(|prio_o), 0);

        // R3 / R4: shared word seen by all, both views
        req("R3 set", 1, 0, 'h004, 4, 32'h0000_00F0, r);
        req("R3 clrview", 0, 3, 'h084, 4, 0, r);
        chk("R3 R4 clear view read of shared word", 64'(r), 64'h0000_00F0);
        req("R3 clr", 1, 5, 'h084, 4, 32'h0000_0030, r);
        req("R3 rd", 0, 1, 'h004, 4, 0, r);
        chk("R3 after clear", 64'(r), 64'h0000_00C0);
        // R4: private word 0
        req("R4 set", 1, 1, 'h000, 4, 32'h0010_0000, r);
        req("R4 other", 0, 2, 'h000, 4, 0, r);
        chk("R4 other cpu word0", 64'(r), 0);
        req("R4 own", 0, 1, 'h080, 4, 0, r);
        chk("R4 own cpu word0", 64'(r), 64'h0010_0000);
        // R5: software-interrupt bits locked
        req("R5 setp", 1, 0, 'h100, 4, 32'hFFFF_FFFF, r);
        chk("R5 upd word 0", 64'(upd_word), 0);
        req("R5 rd", 0, 0, 'h100, 4, 0, r);
        chk("R5 low half unchanged", 64'(r), 64'hFFFF_0000);
        req("R5 clrp", 1, 0, 'h180, 4, 32'h0001_FFFF, r);
        req("R5 rd2", 0, 0, 'h180, 4, 0, r);
        chk("R5 clear pending", 64'(r), 64'hFFFE_0000);
        req("R9 shared", 1, 4, 'h104, 4, 32'h8000_0001, r);
        chk("R9 upd word 1", 64'(upd_word), 1);
        req("R5 shared", 0, 6, 'h104, 4, 0, r);
        chk("R5 shared word full width", 64'(r), 64'h8000_0001);
        req("R9 no strobe on enable", 1, 2, 'h000, 4, 1, r);
        chk("R9 enable write no strobe", 64'(upd_valid), 0);
        // R6: priority lanes and banking
        req("R6 w", 1, 2, 'h400, 4, 32'h4433_2211, r);
        req("R6 b", 0, 2, 'h401, 1, 0, r);
        chk("R6 byte lane", 64'(r), 64'h22);
        req("R6 h", 0, 2, 'h402, 2, 0, r);
        chk("R6 half lane", 64'(r), 64'h4433);
        req("R6 other", 0, 3, 'h400, 4, 0, r);
        chk("R6 private priority", 64'(r), 0);
        req("R6 sw", 1, 0, 'h428, 1, 32'h5A, r);
        req("R6 sr", 0, 5, 'h428, 4, 0, r);
        chk("R6 shared priority", 64'(r), 64'h5A);
        // R7: targets
        req("R7 mask", 0, 5, 'h800, 4, 0, r);
        chk("R7 own mask", 64'(r), 64'h2020_2020);
        req("R7 wign", 1, 5, 'h800, 4, 32'hFFFF_FFFF, r);
        req("R7 mask2", 0, 5, 'h81C, 4, 0, r);
        chk("R7 write ignored", 64'(r), 64'h2020_2020);
        req("R7 sw", 1, 1, 'h822, 2, 32'hBEEF, r);
        req("R7 sr", 0, 7, 'h820, 4, 0, r);
        chk("R7 shared target", 64'(r), 64'hBEEF_0000);
        // R8: refused requests
        req("R8 size3", 1, 0, 'h400, 3, 32'hFF, r);
        chk("R8 size 3 err", 64'(rsp_err), 1);
        req("R8 bit size", 1, 0, 'h000, 2, 32'hFF, r);
        req("R8 misalign", 0, 0, 'h402, 4, 0, r);
        req("R8 hole", 0, 0, 'h300, 4, 0, r);
        chk("R8 hole err", 64'(rsp_err), 1);
        req("R8 word range", 1, 0, 'h008, 4, 32'hFF, r);
        chk("R8 word range err", 64'(rsp_err), 1);
        req("R8 byte range", 0, 0, 'h440, 1, 0, r);
        req("R8 pend err", 1, 0, 'h188, 4, 32'hFFFF_FFFF, r);
        chk("R9 no strobe on error", 64'(upd_valid), 0);

        // Mixed traffic against the model
        for (int n = 0; n < 800; n++) begin
            int sel = $urandom % 10;
            int a, s;
            int szs [4] = '{1, 2, 4, 3};
            if (sel < 5) begin
                a = (($urandom % 3) << 8) | (($urandom % 2) << 7) | (($urandom % 3) << 2);
                s = ($urandom % 8 == 0) ? 2 : 4;
            end else if (sel < 8) begin
                s = szs[$urandom % 4];
                a = 'h400 + ($urandom % 70);
            end else if (sel < 9) begin
                s = szs[$urandom % 4];
                a = 'h800 + ($urandom % 70);
            end else begin
                s = 4;
                a = 'h300 + 4 * ($urandom % 64);
            end
            req("R10 mixed", 1'($urandom % 2), $urandom % NC, a, s, $urandom, r);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule